// File: doc/BRIEF.md
# Segment-Granular Write-Back Data Cache

This block sits between a client that issues 32-bit reads and writes with a per-byte strobe and a memory port that only ever moves whole 32-byte segments. It holds eight direct-mapped lines. Client traffic is served from the lines. Memory is touched only to bring a segment in, or to write a modified segment back when its line is replaced.

A client write to a line that is not present does not fetch anything. The line is claimed for the new address and only the written bytes are marked valid in a 32-bit per-byte mask. When such a partly valid line must leave the cache, the block first reads the segment from memory. It fills every byte the client never wrote from that read, then writes the complete segment back. Memory therefore never needs byte-masked writes. A client read that finds its word only partly valid triggers the same fill, and the line stays dirty.

One memory sequence runs at a time. The client sees `ready` low from the cycle a miss is accepted until the sequence completes. Hits answer on the next cycle.

Top module: `segcache`

## Requirements
- R1: After reset every line is empty and clean. The first access to any index fetches without a write-back, even if lines were dirty before the reset.
- R2: Each memory request carries a segment address equal to byte address bits [31:5] and, for writes, all 256 data bits. A request holds its address and direction while `mem_req_ready_i` is low.
- R3: A read miss issues one memory read of the segment, then responds with word `addr[4:2]` of it, taken from bits [w*32+31:w*32].
- R4: A read whose four bytes are valid and whose tag matches, or a write to a present line, responds on the cycle after acceptance with no memory traffic.
- R5: Client writes change only the cache; a write hit causes no memory transfer.
- R6: A write to a line that is not present claims it without any memory read; bytes it wrote read back unchanged, and the line is marked dirty.
- R7: Evicting a partly valid line performs exactly a memory read of its segment followed by a memory write whose client-written bytes are kept and all other bytes come from the read.
- R8: A read hitting a tag-matched line whose requested bytes are not all valid issues one memory read, responds with the merged word, and leaves the line dirty, so a later eviction writes it with no further read.
- R9: Evicting a fully valid, clean line issues no memory write.
- R10: Evicting a fully valid, dirty line issues one memory write and no read of that segment.
- R11: `cl_req_ready_o` is low whenever a memory request is pending, and a miss response arrives no earlier than two cycles after acceptance.
- R12: Strobe bit i selects byte i of the client word, bits [8i+7:8i]; unstrobed bytes keep their previous line value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cl_req_valid_i | input | 1 | Client request valid |
| cl_req_ready_o | output | 1 | Cache can accept a client request |
| cl_req_write_i | input | 1 | 1 for write, 0 for read |
| cl_req_addr_i | input | 32 | Byte address (bits [1:0] ignored) |
| cl_req_wdata_i | input | 32 | Write data |
| cl_req_strb_i | input | 4 | Byte strobe for writes |
| cl_rsp_valid_o | output | 1 | Response pulse for a completed request |
| cl_rsp_rdata_o | output | 32 | Read data (meaningful for reads) |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_write_o | output | 1 | 1 for segment write, 0 for segment read |
| mem_req_addr_o | output | 27 | Segment address |
| mem_req_wdata_o | output | 256 | Full segment write data |
| mem_rsp_valid_i | input | 1 | Read data returning |
| mem_rsp_rdata_i | input | 256 | Returned segment |

## Verification
A corrupted byte mask shows up at the memory port. The write-back that follows the merge read carries memory bytes where client bytes belong, or the reverse, and this is visible at the first eviction of that line. A stale dirty bit shows as a missing or extra segment write on the next conflicting access. A wrong valid check turns a one-cycle hit into a memory read, seen within a single request. The bench therefore logs every memory transfer and compares the full sequence, including addresses and the 256-bit data, after each client request.

// File: rtl/segcache_pkg.sv
package segcache_pkg;
  localparam int unsigned DEF_ADDR_W     = 32;
  localparam int unsigned DEF_LINES      = 8;
  localparam int unsigned DEF_SEG_BYTES  = 32;
  localparam int unsigned DEF_WORD_BYTES = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_MRG_RQ,
    ST_MRG_WT,
    ST_WB_RQ,
    ST_ALLOC,
    ST_FL_RQ,
    ST_FL_WT
  } cstate_e;
endpackage

// File: rtl/segcache_merge.sv
module segcache_merge #(
  parameter int unsigned SEG_BYTES = 32,
  localparam int unsigned SEG_W = SEG_BYTES * 8
) (
  input  logic [SEG_BYTES-1:0] keep_mask_i,
  input  logic [SEG_W-1:0]     keep_data_i,
  input  logic [SEG_W-1:0]     fill_data_i,
  output logic [SEG_W-1:0]     out_data_o
);
  for (genvar b = 0; b < SEG_BYTES; b++) begin : g_byte
    assign out_data_o[b*8 +: 8] = keep_mask_i[b] ? keep_data_i[b*8 +: 8]
                                                 : fill_data_i[b*8 +: 8];
  end
endmodule

// File: rtl/segcache_store.sv
module segcache_store #(
  parameter int unsigned LINES     = 8,
  parameter int unsigned TAG_W     = 24,
  parameter int unsigned SEG_BYTES = 32,
  localparam int unsigned IDX_W = $clog2(LINES),
  localparam int unsigned SEG_W = SEG_BYTES * 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [IDX_W-1:0]     idx_i,
  output logic [TAG_W-1:0]     rd_tag_o,
  output logic [SEG_W-1:0]     rd_data_o,
  output logic [SEG_BYTES-1:0] rd_mask_o,
  output logic                 rd_dirty_o,
  input  logic                 wr_en_i,
  input  logic [TAG_W-1:0]     wr_tag_i,
  input  logic [SEG_W-1:0]     wr_data_i,
  input  logic [SEG_BYTES-1:0] wr_mask_i,
  input  logic                 wr_dirty_i
);
  logic [TAG_W-1:0]     tag_arr   [LINES];
  logic [SEG_W-1:0]     data_arr  [LINES];
  logic [SEG_BYTES-1:0] mask_arr  [LINES];
  logic                 dirty_arr [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic                 sel;
    logic [TAG_W-1:0]     tag_q;
    logic [SEG_W-1:0]     data_q;
    logic [SEG_BYTES-1:0] mask_q;
    logic                 dirty_q;

    assign sel = wr_en_i && (idx_i == IDX_W'(g));

    // Datapath fields: enable only, no reset.
    always_ff @(posedge clk_i) begin
      if (sel) begin
        tag_q  <= wr_tag_i;
        data_q <= wr_data_i;
      end
    end

    // Control fields: cleared by reset.
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_q  <= '0;
        dirty_q <= 1'b0;
      end else if (sel) begin
        mask_q  <= wr_mask_i;
        dirty_q <= wr_dirty_i;
      end
    end

    assign tag_arr[g]   = tag_q;
    assign data_arr[g]  = data_q;
    assign mask_arr[g]  = mask_q;
    assign dirty_arr[g] = dirty_q;
  end

  assign rd_tag_o   = tag_arr[idx_i];
  assign rd_data_o  = data_arr[idx_i];
  assign rd_mask_o  = mask_arr[idx_i];
  assign rd_dirty_o = dirty_arr[idx_i];
endmodule

// File: rtl/segcache_ctrl.sv
module segcache_ctrl
  import segcache_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINES      = 8,
  parameter int unsigned SEG_BYTES  = 32,
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned OFF_W  = $clog2(SEG_BYTES),
  localparam int unsigned IDX_W  = $clog2(LINES),
  localparam int unsigned TAG_W  = ADDR_W - OFF_W - IDX_W,
  localparam int unsigned SEG_W  = SEG_BYTES * 8,
  localparam int unsigned WORD_W = WORD_BYTES * 8,
  localparam int unsigned BOFF_W = $clog2(WORD_BYTES),
  localparam int unsigned WSEL_W = OFF_W - BOFF_W,
  localparam int unsigned SADR_W = ADDR_W - OFF_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cl_req_valid_i,
  output logic                  cl_req_ready_o,
  input  logic                  cl_req_write_i,
  input  logic [ADDR_W-1:0]     cl_req_addr_i,
  input  logic [WORD_W-1:0]     cl_req_wdata_i,
  input  logic [WORD_BYTES-1:0] cl_req_strb_i,
  output logic                  cl_rsp_valid_o,
  output logic [WORD_W-1:0]     cl_rsp_rdata_o,
  output logic                  mem_req_valid_o,
  input  logic                  mem_req_ready_i,
  output logic                  mem_req_write_o,
  output logic [SADR_W-1:0]     mem_req_addr_o,
  output logic [SEG_W-1:0]      mem_req_wdata_o,
  input  logic                  mem_rsp_valid_i,
  // line store
  output logic [IDX_W-1:0]      idx_o,
  input  logic [TAG_W-1:0]      rd_tag_i,
  input  logic [SEG_W-1:0]      rd_data_i,
  input  logic [SEG_BYTES-1:0]  rd_mask_i,
  input  logic                  rd_dirty_i,
  output logic                  wr_en_o,
  output logic [TAG_W-1:0]      wr_tag_o,
  output logic [SEG_W-1:0]      wr_data_o,
  output logic [SEG_BYTES-1:0]  wr_mask_o,
  output logic                  wr_dirty_o,
  // merge unit result (line bytes kept, memory bytes filled)
  input  logic [SEG_W-1:0]      mrg_data_i
);
  cstate_e state_q, state_d;

  logic                  rq_write_q;
  logic [ADDR_W-1:0]     rq_addr_q;
  logic [WORD_W-1:0]     rq_wdata_q;
  logic [WORD_BYTES-1:0] rq_strb_q;
  logic                  lat_en;

  logic                  rsp_valid_q, rsp_valid_d;
  logic [WORD_W-1:0]     rsp_data_q, rsp_data_d;
  logic                  rsp_en;

  // Current request view: live input in idle, latched copy otherwise.
  logic                  in_idle;
  logic                  cur_write;
  logic [ADDR_W-1:0]     cur_addr;
  logic [WORD_W-1:0]     cur_wdata;
  logic [WORD_BYTES-1:0] cur_strb;
  logic [TAG_W-1:0]      cur_tag;
  logic [IDX_W-1:0]      cur_idx;
  logic [WSEL_W-1:0]     cur_wsel;

  assign in_idle   = (state_q == ST_IDLE);
  assign cur_write = in_idle ? cl_req_write_i : rq_write_q;
  assign cur_addr  = in_idle ? cl_req_addr_i  : rq_addr_q;
  assign cur_wdata = in_idle ? cl_req_wdata_i : rq_wdata_q;
  assign cur_strb  = in_idle ? cl_req_strb_i  : rq_strb_q;
  assign cur_tag   = cur_addr[ADDR_W-1 -: TAG_W];
  assign cur_idx   = cur_addr[OFF_W +: IDX_W];
  assign cur_wsel  = cur_addr[BOFF_W +: WSEL_W];

  logic [BOFF_W-1:0] unused_boff;
  assign unused_boff = cur_addr[BOFF_W-1:0];

  // Byte insertion of the client word into the selected line.
  logic [SEG_W-1:0]      ins_data;
  logic [SEG_BYTES-1:0]  strb_mask;
  logic [WORD_BYTES-1:0] word_valid;
  logic [WORD_W-1:0]     line_word;
  logic [WORD_W-1:0]     mrg_word;
  logic                  present;
  logic                  hit_now;

  always_comb begin
    ins_data  = rd_data_i;
    strb_mask = '0;
    for (int b = 0; b < int'(WORD_BYTES); b++) begin
      if (cur_strb[b]) begin
        ins_data[(int'(cur_wsel) * int'(WORD_BYTES) + b) * 8 +: 8] = cur_wdata[b*8 +: 8];
        strb_mask[int'(cur_wsel) * int'(WORD_BYTES) + b] = 1'b1;
      end
    end
  end

  assign word_valid = rd_mask_i[int'(cur_wsel) * int'(WORD_BYTES) +: WORD_BYTES];
  assign line_word  = rd_data_i[int'(cur_wsel) * int'(WORD_W) +: WORD_W];
  assign mrg_word   = mrg_data_i[int'(cur_wsel) * int'(WORD_W) +: WORD_W];
  assign present    = (rd_mask_i != '0) && (rd_tag_i == cur_tag);
  assign hit_now    = present && (cur_write || (&word_valid));

  // Next-state and datapath control.
  always_comb begin
    state_d     = state_q;
    lat_en      = 1'b0;
    rsp_valid_d = 1'b0;
    rsp_data_d  = rsp_data_q;
    rsp_en      = 1'b0;
    wr_en_o     = 1'b0;
    wr_tag_o    = rd_tag_i;
    wr_data_o   = rd_data_i;
    wr_mask_o   = rd_mask_i;
    wr_dirty_o  = rd_dirty_i;
    unique case (state_q)
      ST_IDLE: begin
        if (cl_req_valid_i) begin
          lat_en = 1'b1;
          if (present && cur_write) begin
            wr_en_o     = 1'b1;
            wr_data_o   = ins_data;
            wr_mask_o   = rd_mask_i | strb_mask;
            wr_dirty_o  = 1'b1;
            rsp_valid_d = 1'b1;
            rsp_data_d  = '0;
            rsp_en      = 1'b1;
          end else if (hit_now) begin
            rsp_valid_d = 1'b1;
            rsp_data_d  = line_word;
            rsp_en      = 1'b1;
          end else if (present) begin
            state_d = ST_FL_RQ;
          end else begin
            state_d = ST_CHECK;
          end
        end
      end
      ST_CHECK: begin
        if (rd_mask_i == '0) begin
          state_d = ST_ALLOC;
        end else if (!(&rd_mask_i)) begin
          state_d = ST_MRG_RQ;
        end else if (rd_dirty_i) begin
          state_d = ST_WB_RQ;
        end else begin
          state_d = ST_ALLOC;
        end
      end
      ST_MRG_RQ: begin
        if (mem_req_ready_i) state_d = ST_MRG_WT;
      end
      ST_MRG_WT: begin
        if (mem_rsp_valid_i) begin
          wr_en_o   = 1'b1;
          wr_data_o = mrg_data_i;
          wr_mask_o = '1;
          state_d   = ST_WB_RQ;
        end
      end
      ST_WB_RQ: begin
        if (mem_req_ready_i) state_d = ST_ALLOC;
      end
      ST_ALLOC: begin
        wr_en_o  = 1'b1;
        wr_tag_o = cur_tag;
        if (cur_write) begin
          wr_data_o   = ins_data;
          wr_mask_o   = strb_mask;
          wr_dirty_o  = 1'b1;
          rsp_valid_d = 1'b1;
          rsp_data_d  = '0;
          rsp_en      = 1'b1;
          state_d     = ST_IDLE;
        end else begin
          wr_mask_o  = '0;
          wr_dirty_o = 1'b0;
          state_d    = ST_FL_RQ;
        end
      end
      ST_FL_RQ: begin
        if (mem_req_ready_i) state_d = ST_FL_WT;
      end
      ST_FL_WT: begin
        if (mem_rsp_valid_i) begin
          wr_en_o     = 1'b1;
          wr_tag_o    = cur_tag;
          wr_data_o   = mrg_data_i;
          wr_mask_o   = '1;
          rsp_valid_d = 1'b1;
          rsp_data_d  = mrg_word;
          rsp_en      = 1'b1;
          state_d     = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      rsp_valid_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_valid_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (lat_en) begin
      rq_write_q <= cl_req_write_i;
      rq_addr_q  <= cl_req_addr_i;
      rq_wdata_q <= cl_req_wdata_i;
      rq_strb_q  <= cl_req_strb_i;
    end
    if (rsp_en) begin
      rsp_data_q <= rsp_data_d;
    end
  end

  assign idx_o           = cur_idx;
  assign cl_req_ready_o  = in_idle;
  assign cl_rsp_valid_o  = rsp_valid_q;
  assign cl_rsp_rdata_o  = rsp_data_q;
  assign mem_req_valid_o = (state_q == ST_MRG_RQ) || (state_q == ST_WB_RQ) ||
                           (state_q == ST_FL_RQ);
  assign mem_req_write_o = (state_q == ST_WB_RQ);
  assign mem_req_addr_o  = (state_q == ST_FL_RQ) ? {cur_tag, cur_idx} : {rd_tag_i, cur_idx};
  assign mem_req_wdata_o = rd_data_i;

  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !cl_req_ready_o); // R11

  AST_MEM_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=>
      (mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_write_o))); // R2

  AST_WB_FULL_DIRTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && mem_req_write_o) |-> ((&rd_mask_i) && rd_dirty_i)); // R9

  AST_HIT_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cl_req_valid_i && cl_req_ready_o && hit_now) |=> cl_rsp_valid_o); // R4

  AST_NO_MEM_ON_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cl_req_valid_i && cl_req_ready_o && hit_now) |=> !mem_req_valid_o); // R5
endmodule

// File: rtl/segcache.sv
module segcache
  import segcache_pkg::*;
#(
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned LINES      = DEF_LINES,
  parameter int unsigned SEG_BYTES  = DEF_SEG_BYTES,
  parameter int unsigned WORD_BYTES = DEF_WORD_BYTES,
  localparam int unsigned OFF_W  = $clog2(SEG_BYTES),
  localparam int unsigned IDX_W  = $clog2(LINES),
  localparam int unsigned TAG_W  = ADDR_W - OFF_W - IDX_W,
  localparam int unsigned SEG_W  = SEG_BYTES * 8,
  localparam int unsigned WORD_W = WORD_BYTES * 8,
  localparam int unsigned SADR_W = ADDR_W - OFF_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cl_req_valid_i,
  output logic                  cl_req_ready_o,
  input  logic                  cl_req_write_i,
  input  logic [ADDR_W-1:0]     cl_req_addr_i,
  input  logic [WORD_W-1:0]     cl_req_wdata_i,
  input  logic [WORD_BYTES-1:0] cl_req_strb_i,
  output logic                  cl_rsp_valid_o,
  output logic [WORD_W-1:0]     cl_rsp_rdata_o,
  output logic                  mem_req_valid_o,
  input  logic                  mem_req_ready_i,
  output logic                  mem_req_write_o,
  output logic [SADR_W-1:0]     mem_req_addr_o,
  output logic [SEG_W-1:0]      mem_req_wdata_o,
  input  logic                  mem_rsp_valid_i,
  input  logic [SEG_W-1:0]      mem_rsp_rdata_i
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic [IDX_W-1:0]     idx;
  logic [TAG_W-1:0]     rd_tag, wr_tag;
  logic [SEG_W-1:0]     rd_data, wr_data, mrg_data;
  logic [SEG_BYTES-1:0] rd_mask, wr_mask;
  logic                 rd_dirty, wr_dirty, wr_en;

  segcache_store #(
    .LINES(LINES), .TAG_W(TAG_W), .SEG_BYTES(SEG_BYTES)
  ) u_store (
    .clk_i(clk_i), .rst_ni(rst_n), .idx_i(idx),
    .rd_tag_o(rd_tag), .rd_data_o(rd_data), .rd_mask_o(rd_mask), .rd_dirty_o(rd_dirty),
    .wr_en_i(wr_en), .wr_tag_i(wr_tag), .wr_data_i(wr_data), .wr_mask_i(wr_mask),
    .wr_dirty_i(wr_dirty)
  );

  segcache_merge #(.SEG_BYTES(SEG_BYTES)) u_merge (
    .keep_mask_i(rd_mask), .keep_data_i(rd_data), .fill_data_i(mem_rsp_rdata_i),
    .out_data_o(mrg_data)
  );

  segcache_ctrl #(
    .ADDR_W(ADDR_W), .LINES(LINES), .SEG_BYTES(SEG_BYTES), .WORD_BYTES(WORD_BYTES)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_n),
    .cl_req_valid_i(cl_req_valid_i), .cl_req_ready_o(cl_req_ready_o),
    .cl_req_write_i(cl_req_write_i), .cl_req_addr_i(cl_req_addr_i),
    .cl_req_wdata_i(cl_req_wdata_i), .cl_req_strb_i(cl_req_strb_i),
    .cl_rsp_valid_o(cl_rsp_valid_o), .cl_rsp_rdata_o(cl_rsp_rdata_o),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_req_write_o(mem_req_write_o), .mem_req_addr_o(mem_req_addr_o),
    .mem_req_wdata_o(mem_req_wdata_o), .mem_rsp_valid_i(mem_rsp_valid_i),
    .idx_o(idx), .rd_tag_i(rd_tag), .rd_data_i(rd_data), .rd_mask_i(rd_mask),
    .rd_dirty_i(rd_dirty), .wr_en_o(wr_en), .wr_tag_o(wr_tag), .wr_data_o(wr_data),
    .wr_mask_o(wr_mask), .wr_dirty_o(wr_dirty), .mrg_data_i(mrg_data)
  );
endmodule

// File: tb/sim_segcache.sv
module sim_segcache;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst_ni;
  logic         cl_req_valid, cl_req_ready, cl_req_write;
  logic [31:0]  cl_req_addr, cl_req_wdata;
  logic [3:0]   cl_req_strb;
  logic         cl_rsp_valid;
  logic [31:0]  cl_rsp_rdata;
  logic         mem_req_valid, mem_req_ready, mem_req_write;
  logic [26:0]  mem_req_addr;
  logic [255:0] mem_req_wdata;
  logic         mem_rsp_valid;
  logic [255:0] mem_rsp_rdata;

  always #(CLK_P/2) clk = ~clk;

  segcache u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .cl_req_valid_i(cl_req_valid), .cl_req_ready_o(cl_req_ready),
    .cl_req_write_i(cl_req_write), .cl_req_addr_i(cl_req_addr),
    .cl_req_wdata_i(cl_req_wdata), .cl_req_strb_i(cl_req_strb),
    .cl_rsp_valid_o(cl_rsp_valid), .cl_rsp_rdata_o(cl_rsp_rdata),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
    .mem_req_write_o(mem_req_write), .mem_req_addr_o(mem_req_addr),
    .mem_req_wdata_o(mem_req_wdata), .mem_rsp_valid_i(mem_rsp_valid),
    .mem_rsp_rdata_i(mem_rsp_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;
  int rsp_seen = 0;
  int ready_viol = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  typedef struct { logic wr; logic [26:0] a; logic [255:0] d; } txn_t;
  txn_t log_q[$];
  logic [255:0] mem_model [logic [26:0]];
  logic [26:0]  pend_a;
  int           pend_cnt = 0;

  function automatic logic [255:0] seg_init(input logic [26:0] a);
    logic [255:0] r;
    for (int b = 0; b < 32; b++) r[b*8 +: 8] = 8'(a[7:0] * 7 + b * 13 + 90);
    return r;
  endfunction

  function automatic logic [255:0] mem_get(input logic [26:0] a);
    if (mem_model.exists(a)) return mem_model[a];
    return seg_init(a);
  endfunction

  always @(posedge clk) begin
    mem_req_ready <= ~mem_req_ready;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      log_q.push_back('{wr: mem_req_write, a: mem_req_addr, d: mem_req_wdata});
      if (mem_req_write) mem_model[mem_req_addr] = mem_req_wdata;
      else begin
        pend_a   <= mem_req_addr;
        pend_cnt <= 3;
      end
    end
    if (pend_cnt != 0) begin
      pend_cnt <= pend_cnt - 1;
      if (pend_cnt == 1) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= mem_get(pend_a);
      end
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct { bit rd; logic [31:0] d; string rq; } exp_t;
  exp_t exp_q[$];

  always @(negedge clk) begin
    if (rst_ni && mem_req_valid && cl_req_ready) ready_viol++;
    if (rst_ni && cl_rsp_valid) begin
      rsp_seen++;
      if (exp_q.size() == 0) chk(1'b0, "R4", "unexpected response", 1, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.rd) chk(cl_rsp_rdata == e.d, e.rq, "read data", cl_rsp_rdata, e.d);
      end
    end
  end

  task automatic do_req(input bit wr, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] s, input logic [31:0] e, input string rq,
                        output int lat);
    int start;
    exp_q.push_back('{rd: !wr, d: e, rq: rq});
    @(negedge clk);
    cl_req_valid = 1'b1;
    cl_req_write = wr;
    cl_req_addr  = a;
    cl_req_wdata = d;
    cl_req_strb  = s;
    while (!cl_req_ready) @(negedge clk);
    @(posedge clk);
    #1 cl_req_valid = 1'b0;
    start = rsp_seen;
    lat = 0;
    do begin
      @(negedge clk);
      #1;
      lat++;
    end while (rsp_seen == start && lat < 200);
    if (rsp_seen == start) chk(1'b0, rq, "no response", 0, 1);
  endtask

  function automatic logic [31:0] mk_addr(input int tag, input int idx, input int w);
    return {24'(tag), 3'(idx), 3'(w), 2'b00};
  endfunction

  function automatic logic [26:0] mk_seg(input int tag, input int idx);
    return {24'(tag), 3'(idx)};
  endfunction

  function automatic logic [31:0] put(input logic [31:0] old, input logic [31:0] d,
                                      input logic [3:0] s);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (s[b]) r[b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] iw(input logic [26:0] seg, input int w);
    logic [255:0] x = seg_init(seg);
    return x[w*32 +: 32];
  endfunction

  task automatic chk_txn(input int pos, input bit wr, input logic [26:0] a,
                         input bit cd, input logic [255:0] d, input string rq);
    if (pos >= log_q.size()) begin
      chk(1'b0, rq, "missing memory transfer", log_q.size(), pos + 1);
    end else begin
      chk(log_q[pos].wr == wr, rq, "transfer direction", log_q[pos].wr, wr);
      chk(log_q[pos].a == a, rq, "segment address", log_q[pos].a, a);
      if (cd) chk(log_q[pos].d == d, rq, "segment data", log_q[pos].d, d);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int lat, n0;
    logic [26:0]  sa, sb, sc, sd, se, sf, sg, sh;
    logic [255:0] ex;
    logic [31:0]  wa, wy, wd;
    sa = mk_seg(1, 0); sb = mk_seg(2, 1); sc = mk_seg(3, 1); sd = mk_seg(4, 2);
    se = mk_seg(5, 2); sf = mk_seg(6, 0); sg = mk_seg(7, 1); sh = mk_seg(8, 0);
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_rdata = '0;
    cl_req_valid = 1'b0; cl_req_write = 1'b0; cl_req_addr = '0;
    cl_req_wdata = '0; cl_req_strb = '0;
    rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state at the ports
    chk(cl_req_ready == 1'b1, "R1", "ready after reset", cl_req_ready, 1);
    chk(cl_rsp_valid == 1'b0, "R1", "rsp idle after reset", cl_rsp_valid, 0);
    chk(mem_req_valid == 1'b0, "R1", "mem idle after reset", mem_req_valid, 0);

    // R3 / R2: read miss fetches the segment
    n0 = log_q.size();
    do_req(1'b0, mk_addr(1, 0, 2), 0, 0, iw(sa, 2), "R3", lat);
    chk(log_q.size() == n0 + 1, "R3", "one fetch on miss", log_q.size() - n0, 1);
    chk_txn(n0, 1'b0, sa, 1'b0, '0, "R2");
    chk(lat >= 2, "R11", "miss latency", lat, 2);

    // R4: read hit
    n0 = log_q.size();
    do_req(1'b0, mk_addr(1, 0, 5), 0, 0, iw(sa, 5), "R4", lat);
    chk(lat == 1, "R4", "read hit latency", lat, 1);
    chk(log_q.size() == n0, "R4", "no transfer on hit", log_q.size() - n0, 0);

    // R5: write hit stays in cache
    wa = 32'hAABBCCDD;
    n0 = log_q.size();
    do_req(1'b1, mk_addr(1, 0, 2), wa, 4'b0101, 0, "R5", lat);
    chk(lat == 1, "R4", "write hit latency", lat, 1);
    chk(log_q.size() == n0, "R5", "no transfer on write", log_q.size() - n0, 0);

    // R12: strobe byte placement
    do_req(1'b0, mk_addr(1, 0, 2), 0, 0, put(iw(sa, 2), wa, 4'b0101), "R12", lat);

    // R6: write miss allocates without fetching
    n0 = log_q.size();
    do_req(1'b1, mk_addr(2, 1, 0), 32'hCAFEF00D, 4'b1111, 0, "R6", lat);
    wy = 32'h12345678;
    do_req(1'b1, mk_addr(2, 1, 3), wy, 4'b0011, 0, "R6", lat);
    chk(log_q.size() == n0, "R6", "no fetch on write miss", log_q.size() - n0, 0);
    do_req(1'b0, mk_addr(2, 1, 0), 0, 0, 32'hCAFEF00D, "R6", lat);
    chk(lat == 1, "R6", "written word is a hit", lat, 1);

    // R8: partly valid read fetches and merges
    n0 = log_q.size();
    do_req(1'b0, mk_addr(2, 1, 3), 0, 0, put(iw(sb, 3), wy, 4'b0011), "R8", lat);
    chk(log_q.size() == n0 + 1, "R8", "one fill read", log_q.size() - n0, 1);
    chk_txn(n0, 1'b0, sb, 1'b0, '0, "R8");

    // R10 / R8: full dirty line evicted with a write only
    ex = seg_init(sb);
    ex[0 +: 32]  = 32'hCAFEF00D;
    ex[96 +: 32] = put(iw(sb, 3), wy, 4'b0011);
    n0 = log_q.size();
    do_req(1'b0, mk_addr(3, 1, 1), 0, 0, iw(sc, 1), "R10", lat);
    chk(log_q.size() == n0 + 2, "R10", "write-back then fetch", log_q.size() - n0, 2);
    chk_txn(n0, 1'b1, sb, 1'b1, ex, "R8");
    chk_txn(n0 + 1, 1'b0, sc, 1'b0, '0, "R10");

    // R9: clean line dropped
    n0 = log_q.size();
    do_req(1'b0, mk_addr(7, 1, 4), 0, 0, iw(sg, 4), "R9", lat);
    chk(log_q.size() == n0 + 1, "R9", "no write for clean line", log_q.size() - n0, 1);
    chk_txn(n0, 1'b0, sg, 1'b0, '0, "R9");

    // R7: partial line evicted with read-merge-write
    wd = 32'h11223344;
    do_req(1'b1, mk_addr(4, 2, 7), wd, 4'b1000, 0, "R6", lat);
    n0 = log_q.size();
    do_req(1'b1, mk_addr(5, 2, 0), 32'h55667788, 4'b1111, 0, "R7", lat);
    ex = seg_init(sd);
    ex[224 +: 32] = put(iw(sd, 7), wd, 4'b1000);
    chk(log_q.size() == n0 + 2, "R7", "merge transfers", log_q.size() - n0, 2);
    chk_txn(n0, 1'b0, sd, 1'b0, '0, "R7");
    chk_txn(n0 + 1, 1'b1, sd, 1'b1, ex, "R7");

    // R7 round trip: evict partial E, read back D from memory
    n0 = log_q.size();
    do_req(1'b0, mk_addr(4, 2, 7), 0, 0, put(iw(sd, 7), wd, 4'b1000), "R7", lat);
    ex = seg_init(se);
    ex[0 +: 32] = 32'h55667788;
    chk(log_q.size() == n0 + 3, "R7", "evict then fetch", log_q.size() - n0, 3);
    chk_txn(n0, 1'b0, se, 1'b0, '0, "R7");
    chk_txn(n0 + 1, 1'b1, se, 1'b1, ex, "R7");
    chk_txn(n0 + 2, 1'b0, sd, 1'b0, '0, "R7");

    // R10: dirty full line A (written on a hit) evicted
    ex = seg_init(sa);
    ex[64 +: 32] = put(iw(sa, 2), wa, 4'b0101);
    n0 = log_q.size();
    do_req(1'b0, mk_addr(6, 0, 0), 0, 0, iw(sf, 0), "R10", lat);
    chk(log_q.size() == n0 + 2, "R10", "write-back then fetch", log_q.size() - n0, 2);
    chk_txn(n0, 1'b1, sa, 1'b1, ex, "R10");
    chk_txn(n0 + 1, 1'b0, sf, 1'b0, '0, "R10");

    // R1: reset discards dirty lines
    do_req(1'b1, mk_addr(6, 0, 0), 32'h01020304, 4'b1111, 0, "R5", lat);
    @(posedge clk);
    #1 rst_ni = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_ni = 1'b1;
    repeat (3) @(posedge clk);
    n0 = log_q.size();
    do_req(1'b0, mk_addr(8, 0, 1), 0, 0, iw(sh, 1), "R1", lat);
    chk(log_q.size() == n0 + 1, "R1", "no write-back after reset", log_q.size() - n0, 1);
    chk_txn(n0, 1'b0, sh, 1'b0, '0, "R1");

    // R11: client never ready while memory busy
    chk(ready_viol == 0, "R11", "ready high during memory request", ready_viol, 0);
    chk(exp_q.size() == 0, "R4", "responses outstanding", exp_q.size(), 0);
    finish_run();
  end
endmodule